// File: doc/BRIEF.md
# Double-Buffered Serial Line Transmitter

This block sends characters on an asynchronous serial line. A host writes a character into a holding register, and that write also clears the buffer-empty flag. The engine copies the character into its own shift register, raises the empty flag again, and then shifts out one frame. A frame is a low start bit, then the data bits least significant first, then an optional trailing bit that carries either parity or a host-supplied address marker, and finally a high stop bit. Because the holding register and the shift register are separate, the host can queue the next character while the current one is still on the line.

The engine checks the empty flag at the moment the stop bit begins. If a character is waiting, the engine takes it at that moment, and its start bit follows the stop bit with no idle time between them. If nothing is waiting, the engine sets the end-of-transmission flag and the line rests high after the stop bit. Two interrupt outputs report the empty flag and the end flag, and each has its own enable bit. The bit rate comes from a programmable prescaler. Each bit lasts sixteen prescaler ticks.

The host side is a plain strobe interface with no back-pressure. The block accepts every write in the cycle it is presented. A data write made while a character is still pending replaces that character, so the host must wait for the empty flag before it writes again. A read returns the addressed register one cycle after the read strobe.

Top module: `sertx_engine`

## Requirements
- R1: After reset, `txd` is 1, both interrupt outputs are 0, and the status register reads 0x03 (empty flag = bit 0 = 1, end flag = bit 1 = 1). Whenever the engine is idle, `txd` is 1.
- R2: Register addresses: 0 = control, 1 = transmit holding data, 2 = status (read-only), 3 = prescaler. Control resets to 0x00 and the prescaler resets to 15 (0x0F). Control and prescaler read back the value last written.
- R3: A write to address 1 clears both the empty flag and the end flag on the next clock edge.
- R4: Control bit 0 enables transmission. When this bit is 1, the engine is idle and the empty flag is 0, the engine loads the holding register on the next clock edge, sets the empty flag, and drives the start bit.
- R5: A frame is a start bit (0), then the data bits LSB first, then the optional trailing bit, then a stop bit (1). Each bit lasts 16*(prescaler+1) clock cycles.
- R6: Control bit 3 enables a parity bit after the data bits. Control bit 4 selects odd parity when set and even parity when clear. Parity is computed over the data bits that are actually sent.
- R7: Control bit 5 selects 7-bit characters: only holding bits [6:0] are sent, and the parity covers only those bits.
- R8: Control bit 6 enables the marker bit. When it is enabled, the trailing bit is always sent and equals control bit 7, and this takes precedence over parity.
- R9: If the empty flag is 0 when the stop bit begins, the next frame's start bit follows the stop bit directly, with no idle cycle between the frames.
- R10: If the empty flag is 1 when the stop bit begins, the end flag is set at that moment. After the stop bit the line then stays at 1 and no further frame is sent.
- R11: `irq_empty` equals the empty flag AND control bit 1. `irq_end` equals the end flag AND control bit 2.
- R12: If a data write falls in the same cycle as the engine loading the holding register, the write takes priority. The empty flag stays 0, and the newly written character is sent after the current one.
- R13: While control bit 0 is 0, the idle engine does not load the holding register. `txd` stays 1 and the empty flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| txd | output | 1 | Serial line output, high when idle |
| irq_empty | output | 1 | Holding register empty interrupt |
| irq_end | output | 1 | Transmission ended interrupt |

## Verification
The host data write and the engine's load of the holding register can land on the same clock edge. In that cycle, one side clears the empty flag and the other sets it. The bench provokes this by issuing two data writes on consecutive edges while the engine is idle: the engine takes the first character on the same edge that the second one arrives. The result is judged at the ports. The status register must show the flag still clear, and the serial monitor must decode both characters in order, with the second frame starting exactly one frame length after the first.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_DIV  = 2'd3
  } reg_addr_e;

  // Field order fixes the bit positions: mp_val is bit 7, tx_en is bit 0.
  typedef struct packed {
    logic mp_val;
    logic mp_en;
    logic short_len;
    logic par_odd;
    logic par_en;
    logic end_ie;
    logic empty_ie;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } tx_state_e;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bit_done
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic             tick;

  assign tick     = run && (pre_q == div);
  assign bit_done = tick && (sub_q == SUB_LAST);

  // Both counters sit at zero while idle, so the first bit of a frame
  // gets its full length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (!run) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             eng_load,
  input  logic             eng_end,
  output ctrl_t            ctrl_q,
  output logic [DIV_W-1:0] div_q,
  output logic [REG_W-1:0] hold_q,
  output logic             empty_q,
  output logic             done_q,
  output logic             irq_empty,
  output logic             irq_end
);
  reg_addr_e        sel;
  logic             wr_ctrl, wr_data, wr_div;
  logic [REG_W-1:0] rd_mux;

  assign sel     = reg_addr_e'(host_addr);
  assign wr_ctrl = host_wr && (sel == ADDR_CTRL);
  assign wr_data = host_wr && (sel == ADDR_DATA);
  assign wr_div  = host_wr && (sel == ADDR_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RESET);
      hold_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(host_wdata);
      if (wr_div)  div_q  <= DIV_W'(host_wdata);
      if (wr_data) hold_q <= host_wdata;
    end
  end

  // The host write wins over the engine's update of the same flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else begin
      if (wr_data)       empty_q <= 1'b0;
      else if (eng_load) empty_q <= 1'b1;
      if (wr_data)       done_q  <= 1'b0;
      else if (eng_end)  done_q  <= 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      ADDR_CTRL: rd_mux = ctrl_q;
      ADDR_DATA: rd_mux = hold_q;
      ADDR_STAT: rd_mux = REG_W'({done_q, empty_q});
      default:   rd_mux = REG_W'(div_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  assign irq_empty = empty_q && ctrl_q.empty_ie;
  assign irq_end   = done_q && ctrl_q.end_ie;
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_done,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] hold,
  input  logic              empty,
  output logic              take,
  output logic              mark_end,
  output logic              busy,
  output logic              txd
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              short_q, short_d;
  logic              xen_q, xen_d;
  logic              xval_q, xval_d;
  logic              chain_q, chain_d;
  logic              ready, go_stop;

  function automatic logic calc_extra(input ctrl_t c, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] m;
    m = d;
    if (c.short_len) m[DATA_W-1] = 1'b0;
    if (c.mp_en) return c.mp_val;
    return (^m) ^ c.par_odd;
  endfunction

  assign ready = ctrl.tx_en && !empty;

  always_comb begin
    state_d  = state_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    short_d  = short_q;
    xen_d    = xen_q;
    xval_d   = xval_q;
    chain_d  = chain_q;
    take     = 1'b0;
    mark_end = 1'b0;
    go_stop  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ready) begin
        take    = 1'b1;
        state_d = ST_START;
      end
      ST_START: if (bit_done) begin
        state_d = ST_DATA;
        cnt_d   = '0;
      end
      ST_DATA: if (bit_done) begin
        sh_d = sh_q >> 1;
        if (cnt_q == (short_q ? LAST_SHORT : LAST_LONG)) begin
          if (xen_q) state_d = ST_EXTRA;
          else       go_stop = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_EXTRA: if (bit_done) go_stop = 1'b1;
      ST_STOP: if (bit_done) state_d = chain_q ? ST_START : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    // The empty flag is sampled once, on entry to the stop bit.
    if (go_stop) begin
      state_d = ST_STOP;
      if (ready) begin
        take    = 1'b1;
        chain_d = 1'b1;
      end else begin
        mark_end = 1'b1;
        chain_d  = 1'b0;
      end
    end
    if (take) begin
      sh_d    = hold;
      short_d = ctrl.short_len;
      xen_d   = ctrl.par_en | ctrl.mp_en;
      xval_d  = calc_extra(ctrl, hold);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      short_q <= 1'b0;
      xen_q   <= 1'b0;
      xval_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      short_q <= short_d;
      xen_q   <= xen_d;
      xval_q  <= xval_d;
      chain_q <= chain_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh_q[0];
      ST_EXTRA: txd = xval_q;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 15,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             txd,
  output logic             irq_empty,
  output logic             irq_end
);
  ctrl_t            ctrl;
  logic [DIV_W-1:0] div;
  logic [REG_W-1:0] hold;
  logic             flag_empty, flag_end;
  logic             load_go, end_go, busy, bit_tick;
  logic             tx_on, host_data_wr;

  assign tx_on        = ctrl.tx_en;
  assign host_data_wr = reg_wr && (reg_addr == ADDR_DATA);

  sertx_regs #(
    .DIV_W(DIV_W),
    .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk(clk),
    .rst_n(rst_n),
    .host_wr(reg_wr),
    .host_rd(reg_rd),
    .host_addr(reg_addr),
    .host_wdata(reg_wdata),
    .host_rdata(reg_rdata),
    .eng_load(load_go),
    .eng_end(end_go),
    .ctrl_q(ctrl),
    .div_q(div),
    .hold_q(hold),
    .empty_q(flag_empty),
    .done_q(flag_end),
    .irq_empty(irq_empty),
    .irq_end(irq_end)
  );

  sertx_baud #(
    .DIV_W(DIV_W),
    .OVS(OVERSAMPLE)
  ) u_baud (
    .clk(clk),
    .rst_n(rst_n),
    .run(busy),
    .div(div),
    .bit_done(bit_tick)
  );

  sertx_shift #(
    .DATA_W(REG_W)
  ) u_shift (
    .clk(clk),
    .rst_n(rst_n),
    .bit_done(bit_tick),
    .ctrl(ctrl),
    .hold(hold),
    .empty(flag_empty),
    .take(load_go),
    .mark_end(end_go),
    .busy(busy),
    .txd(txd)
  );
endmodule

// File: rtl/sertx_checks.sv
module sertx_checks (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic busy,
  input logic flag_empty,
  input logic flag_end,
  input logic load_go,
  input logic end_go,
  input logic bit_tick,
  input logic host_data_wr,
  input logic tx_on,
  input logic irq_empty,
  input logic irq_end
);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_wr |=> (!flag_empty && !flag_end));

  assert_load_sets_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && !host_data_wr) |=> flag_empty);

  assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_tick)) |-> $stable(txd));

  assert_end_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_go && !host_data_wr) |=> flag_end);

  assert_end_needs_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_end) |-> flag_empty);

  assert_irq_empty_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> flag_empty);

  assert_irq_end_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> flag_end);

  assert_collision_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_wr && load_go) |=> !flag_empty);

  assert_disabled_stays_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_on && !busy) |=> !busy);
endmodule

bind sertx_engine sertx_checks u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .txd(txd),
  .busy(busy),
  .flag_empty(flag_empty),
  .flag_end(flag_end),
  .load_go(load_go),
  .end_go(end_go),
  .bit_tick(bit_tick),
  .host_data_wr(host_data_wr),
  .tx_on(tx_on),
  .irq_empty(irq_empty),
  .irq_end(irq_end)
);

// File: tb/sertx_engine_test.sv
`timescale 1ns/1ps
module sertx_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       txd, irq_empty, irq_end;

  sertx_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txd(txd), .irq_empty(irq_empty), .irq_end(irq_end)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pbit = 256;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0] data;
    int         nbits;
    bit         xen;
    bit         xval;
    bit         gap;
    string      req;
  } frame_t;

  frame_t expq[$];

  bit c_en, c_eie, c_tie, c_par, c_odd, c_short, c_mp, c_mpv;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic write_ctrl();
    reg_write(2'd0, {c_mpv, c_mp, c_short, c_odd, c_par, c_tie, c_eie, c_en});
  endtask

  task automatic push_expect(input logic [7:0] d, input bit gap);
    frame_t f;
    logic [7:0] m;
    m = d;
    if (c_short) m[7] = 1'b0;
    f.data  = m;
    f.nbits = c_short ? 7 : 8;
    f.xen   = c_par | c_mp;
    f.xval  = c_mp ? c_mpv : ((($countones(m) % 2) == 1) ^ c_odd);
    f.gap   = gap;
    f.req   = c_mp ? "R8" : (c_short ? "R7" : (c_par ? "R6" : "R5"));
    expq.push_back(f);
  endtask

  task automatic send(input logic [7:0] d, input bit gap);
    push_expect(d, gap);
    reg_write(2'd1, d);
  endtask

  task automatic wait_empty();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      reg_read(2'd2, s);
      if (s[0]) break;
    end
  endtask

  task automatic finish_frames(input string req);
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_read(2'd2, s);
      if (s[1]) break;
    end
    repeat (2 * pbit) @(negedge clk);
    check(expq.size() == 0, req, "frames not received", expq.size(), 0);
  endtask

  // Monitor: decodes the serial line and compares it with the scoreboard queue.
  initial begin : monitor
    logic prev, st0, gx, sp;
    logic [7:0] got;
    int start_c, last_start, last_bits;
    frame_t f;
    prev = 1'b1; last_start = 0; last_bits = 0;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        start_c = cyc;
        if (expq.size() == 0) begin
          check(1'b0, "R10", "unexpected frame", 1, 0);
          f.data = 8'h00; f.nbits = 8; f.xen = 1'b0; f.xval = 1'b0;
          f.gap = 1'b0; f.req = "R10";
        end else begin
          f = expq.pop_front();
        end
        if (f.gap)
          check(start_c == last_start + last_bits * pbit, "R9",
                "back-to-back start cycle", start_c, last_start + last_bits * pbit);
        repeat (pbit / 2) @(negedge clk);
        st0 = txd;
        got = 8'h00;
        gx = 1'b0;
        for (int i = 0; i < f.nbits; i++) begin
          repeat (pbit) @(negedge clk);
          got[i] = txd;
        end
        if (f.xen) begin
          repeat (pbit) @(negedge clk);
          gx = txd;
        end
        repeat (pbit) @(negedge clk);
        sp = txd;
        check(st0 == 1'b0, "R5", "start bit", st0, 0);
        check(got == f.data, f.req, "data bits", got, f.data);
        if (f.xen) check(gx == f.xval, f.req, "trailing bit", gx, f.xval);
        check(sp == 1'b1, "R5", "stop bit", sp, 1);
        last_start = start_c;
        last_bits  = 2 + f.nbits + (f.xen ? 1 : 0);
      end
      prev = txd;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    bit ok;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1", "txd in reset", txd, 1);
    check(irq_empty == 1'b0 && irq_end == 1'b0, "R1", "irqs in reset",
          {irq_empty, irq_end}, 0);
    rst_n = 1'b1;
    reg_read(2'd2, r);
    check(r == 8'h03, "R1", "status after reset", r, 8'h03);
    reg_read(2'd0, r);
    check(r == 8'h00, "R2", "control after reset", r, 8'h00);
    reg_read(2'd3, r);
    check(r == 8'h0F, "R2", "prescaler after reset", r, 8'h0F);
    reg_write(2'd3, 8'h01);
    pbit = 32;
    reg_read(2'd3, r);
    check(r == 8'h01, "R2", "prescaler readback", r, 8'h01);

    // R13: transmission disabled, data must stay pending
    reg_write(2'd1, 8'h5A);
    ok = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (!txd) ok = 1'b0;
    end
    check(ok, "R13", "line stays mark while disabled", ok, 1);
    reg_read(2'd2, r);
    check(r == 8'h00, "R3", "flags cleared by write, buffer kept", r, 8'h00);
    c_en = 1'b1;
    push_expect(8'h5A, 1'b0);
    write_ctrl();
    reg_read(2'd0, r);
    check(r == 8'h01, "R2", "control readback", r, 8'h01);
    finish_frames("R13");
    reg_read(2'd2, r);
    check(r == 8'h03, "R10", "status after last frame", r, 8'h03);
    check(irq_empty == 1'b0 && irq_end == 1'b0, "R11", "irqs masked",
          {irq_empty, irq_end}, 0);

    // R11 and R4: interrupt gating and load timing
    c_eie = 1'b1; c_tie = 1'b1;
    write_ctrl();
    check(irq_empty == 1'b1 && irq_end == 1'b1, "R11", "irqs enabled",
          {irq_empty, irq_end}, 3);
    send(8'hC3, 1'b0);
    check(irq_empty == 1'b0 && irq_end == 1'b0, "R11", "irqs after write",
          {irq_empty, irq_end}, 0);
    check(txd == 1'b1, "R4", "no start before load edge", txd, 1);
    @(negedge clk);
    check(txd == 1'b0, "R4", "start bit one edge after write", txd, 0);
    check(irq_empty == 1'b1, "R4", "empty set by load", irq_empty, 1);
    finish_frames("R5");
    check(irq_end == 1'b1, "R11", "end irq after frame", irq_end, 1);
    c_eie = 1'b0; c_tie = 1'b0;
    write_ctrl();
    check(irq_empty == 1'b0 && irq_end == 1'b0, "R11", "irqs disabled again",
          {irq_empty, irq_end}, 0);

    // R6: parity
    c_par = 1'b1; c_odd = 1'b0;
    write_ctrl();
    send(8'hA7, 1'b0);
    finish_frames("R6");
    c_odd = 1'b1;
    write_ctrl();
    send(8'h3C, 1'b0);
    finish_frames("R6");

    // R7: 7-bit characters
    c_short = 1'b1; c_odd = 1'b0;
    write_ctrl();
    send(8'hFF, 1'b0);
    finish_frames("R7");
    send(8'h80, 1'b0);
    finish_frames("R7");

    // R8: marker bit takes precedence over parity
    c_short = 1'b0; c_mp = 1'b1; c_mpv = 1'b1;
    write_ctrl();
    send(8'h00, 1'b0);
    finish_frames("R8");
    c_mpv = 1'b0; c_odd = 1'b1;
    write_ctrl();
    send(8'hFF, 1'b0);
    finish_frames("R8");

    // R9: chained frames
    c_mp = 1'b0; c_mpv = 1'b0; c_par = 1'b0; c_odd = 1'b0;
    write_ctrl();
    send(8'h11, 1'b0);
    wait_empty();
    send(8'h22, 1'b1);
    reg_read(2'd2, r);
    check(r == 8'h00, "R3", "status with byte pending", r, 8'h00);
    wait_empty();
    send(8'h33, 1'b1);
    finish_frames("R9");
    ok = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (!txd) ok = 1'b0;
    end
    check(ok, "R10", "line mark after end", ok, 1);

    // R12: write lands on the same edge as the engine's load
    push_expect(8'h6B, 1'b0);
    push_expect(8'h94, 1'b1);
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = 8'h6B; reg_wr = 1'b1;
    @(negedge clk);
    reg_wdata = 8'h94;
    @(negedge clk);
    reg_wr = 1'b0;
    check(txd == 1'b0, "R12", "first byte started", txd, 0);
    reg_read(2'd2, r);
    check(r == 8'h00, "R12", "empty stays clear after collision", r, 8'h00);
    finish_frames("R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule